// File: doc/BRIEF.md
# Quad-nibble protection register slave

This block is the device-side decoder for the protection-register commands of a serial memory with a four-bit data bus. While chip select is low, the host clocks one nibble per SCK cycle on the bus. Each byte takes two SCK cycles, with the upper nibble first. The opening byte of every transaction is an opcode.

The block recognises two opcodes. A read opcode makes the block stream the protection register back to the host. A write opcode collects a new register value and applies it when chip select goes high. Any other opcode makes the block ignore the bus until the next transaction. The current register value is also brought out on a parallel port, so that the array control logic can use it. The register width is a parameter: 48 bits for the small device, 80 bits for the large one.

The block runs on a local clock that is fast compared to SCK. It finds the SCK edges and the end of chip select by comparing each input with its value one clock earlier. Both SCK idle levels work: low (mode 0) and high (mode 3).

Top module: `quad_prot_slave`

## Requirements
- R1: After an asynchronous reset, prot_o equals RESET_VAL (all ones by default) and sio_oe_o is 0. This also holds when reset is applied in the middle of a transaction.
- R2: While cs_ni is low, a nibble is taken from sio_i on each rising SCK edge. The first two nibbles form the opcode, upper nibble first. 0x72 selects a read and 0x42 selects a write. The swapped value 0x24 is not a write.
- R3: On a read, the falling SCK edge after the opcode's second nibble places bits [REG_BITS-1:REG_BITS-4] on sio_o. Each later falling edge presents the next lower nibble, so the 48-bit register ends with bits [3:0] on its 12th nibble.
- R4: A read does not wrap around. Every nibble after the lowest one is 0x0 until cs_ni rises.
- R5: sio_oe_o is 1 only in the data phase of a read. It is 0 during opcode nibbles, during writes, after an unknown opcode, and once cs_ni is high.
- R6: A write is applied when cs_ni rises after exactly REG_BITS/4 data nibbles (12 nibbles at 48 bits, 20 at 80). The first data nibble lands in the top four bits of the register.
- R7: A write that ends with fewer or more data nibbles than required leaves prot_o unchanged.
- R8: After an opcode other than 0x72 or 0x42, the rest of the transaction has no effect. prot_o stays as it was and sio_oe_o stays 0.
- R9: Transactions behave the same whether SCK idles low or high while cs_ni is high.
- R10: REG_BITS selects a 48-bit or an 80-bit register, and with it the required write length.
- R11: prot_o changes only in the clock after cs_ni rises. sio_o changes only in the clock after a falling SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| sio_i | input | 4 | Nibble driven by the host |
| sio_o | output | 4 | Nibble driven to the host |
| sio_oe_o | output | 1 | Output enable for sio_o |
| prot_o | output | REG_BITS | Current protection register value |

## Verification
A lost or extra nibble count shows up as a read stream shifted by a nibble, starting with the very first data nibble. It can also show up as a write that is refused or wrongly accepted, and that is visible in prot_o one clock after cs_ni rises. A wrong phase decode, for example treating 0x24 as a write or failing to clear the state between transactions, shows up in sio_oe_o during the following nibble or in prot_o at the end of that transaction. A read that wraps around, or that does not fill with zeros, differs from the expected value on the first nibble after the register has been fully sent. For that reason the reads run well past the register length.

// File: rtl/qsl_pkg.sv
package qsl_pkg;
  localparam logic [7:0] OPC_READ  = 8'h72;
  localparam logic [7:0] OPC_WRITE = 8'h42;

  typedef enum logic [1:0] {
    PH_OPC,
    PH_RD,
    PH_WR,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/qsl_edge.sv
module qsl_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_end_o
);
  logic sck_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
    end
  end

  assign sck_rise_o = ~cs_ni & sck_i & ~sck_q;
  assign sck_fall_o = ~cs_ni & ~sck_i & sck_q;
  assign cs_end_o   = cs_ni & ~cs_q;
endmodule

// File: rtl/qsl_ctl.sv
module qsl_ctl
  import qsl_pkg::*;
#(
  parameter int NIBS = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_rise_i,
  input  logic [3:0] sio_i,
  output phase_e     phase_o,
  output logic       rd_start_o,
  output logic       wr_shift_o,
  output logic       wr_exact_o
);
  localparam int CW = $clog2(NIBS + 2);
  localparam logic [CW-1:0] CNT_MAX = CW'(NIBS + 1);
  localparam logic [CW-1:0] CNT_OK  = CW'(NIBS);

  phase_e          phase_q;
  logic [3:0]      opc_hi_q;
  logic            opc_half_q;
  logic [CW-1:0]   wr_cnt_q;
  logic [7:0]      opc;

  assign opc = {opc_hi_q, sio_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_OPC;
      opc_hi_q   <= 4'h0;
      opc_half_q <= 1'b0;
      wr_cnt_q   <= '0;
    end else if (cs_ni) begin
      phase_q    <= PH_OPC;
      opc_half_q <= 1'b0;
      wr_cnt_q   <= '0;
    end else if (sck_rise_i) begin
      unique case (phase_q)
        PH_OPC: begin
          if (!opc_half_q) begin
            opc_hi_q   <= sio_i;
            opc_half_q <= 1'b1;
          end else begin
            case (opc)
              OPC_READ:  phase_q <= PH_RD;
              OPC_WRITE: phase_q <= PH_WR;
              default:   phase_q <= PH_SKIP;
            endcase
          end
        end
        PH_WR: if (wr_cnt_q != CNT_MAX) wr_cnt_q <= wr_cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign rd_start_o = sck_rise_i & (phase_q == PH_OPC) & opc_half_q & (opc == OPC_READ);
  assign wr_shift_o = sck_rise_i & (phase_q == PH_WR);
  assign wr_exact_o = (wr_cnt_q == CNT_OK);
endmodule

// File: rtl/qsl_reg.sv
module qsl_reg
  import qsl_pkg::*;
#(
  parameter int                  REG_BITS  = 48,
  parameter logic [REG_BITS-1:0] RESET_VAL = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                cs_end_i,
  input  logic                sck_fall_i,
  input  phase_e              phase_i,
  input  logic                rd_start_i,
  input  logic                wr_shift_i,
  input  logic                wr_exact_i,
  input  logic [3:0]          sio_i,
  output logic [REG_BITS-1:0] prot_o,
  output logic [3:0]          sio_o,
  output logic                sio_oe_o
);
  logic [REG_BITS-1:0] prot_q, wr_sh_q, rd_sh_q;
  logic [3:0]          sio_q;
  logic                oe_q;

  // Write staging: applied only at chip-select release with an exact count.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q  <= RESET_VAL;
      wr_sh_q <= '0;
    end else begin
      if (wr_shift_i) wr_sh_q <= {wr_sh_q[REG_BITS-5:0], sio_i};
      if (cs_end_i && phase_i == PH_WR && wr_exact_i) prot_q <= wr_sh_q;
    end
  end

  // Read shifter: zeros enter at the bottom, so the tail reads as 0x0.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sh_q <= '0;
      sio_q   <= 4'h0;
      oe_q    <= 1'b0;
    end else if (cs_ni) begin
      oe_q <= 1'b0;
    end else if (rd_start_i) begin
      rd_sh_q <= prot_q;
    end else if (sck_fall_i && phase_i == PH_RD) begin
      sio_q   <= rd_sh_q[REG_BITS-1 -: 4];
      rd_sh_q <= {rd_sh_q[REG_BITS-5:0], 4'h0};
      oe_q    <= 1'b1;
    end
  end

  assign prot_o   = prot_q;
  assign sio_o    = sio_q;
  assign sio_oe_o = oe_q;
endmodule

// File: rtl/quad_prot_slave.sv
module quad_prot_slave
  import qsl_pkg::*;
#(
  parameter int                  REG_BITS  = 48,
  parameter logic [REG_BITS-1:0] RESET_VAL = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                cs_ni,
  input  logic [3:0]          sio_i,
  output logic [3:0]          sio_o,
  output logic                sio_oe_o,
  output logic [REG_BITS-1:0] prot_o
);
  localparam int NIBS = REG_BITS / 4;

  logic   sck_rise, sck_fall, cs_end;
  logic   rd_start, wr_shift, wr_exact;
  phase_e phase;

  qsl_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .cs_ni      (cs_ni),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .cs_end_o   (cs_end)
  );

  qsl_ctl #(.NIBS(NIBS)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sck_rise_i (sck_rise),
    .sio_i      (sio_i),
    .phase_o    (phase),
    .rd_start_o (rd_start),
    .wr_shift_o (wr_shift),
    .wr_exact_o (wr_exact)
  );

  qsl_reg #(.REG_BITS(REG_BITS), .RESET_VAL(RESET_VAL)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .cs_end_i   (cs_end),
    .sck_fall_i (sck_fall),
    .phase_i    (phase),
    .rd_start_i (rd_start),
    .wr_shift_i (wr_shift),
    .wr_exact_i (wr_exact),
    .sio_i      (sio_i),
    .prot_o     (prot_o),
    .sio_o      (sio_o),
    .sio_oe_o   (sio_oe_o)
  );
endmodule

// File: rtl/quad_prot_slave_chk.sv
module quad_prot_slave_chk #(
  parameter int REG_BITS = 48
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sck_i,
  input logic                cs_ni,
  input logic [3:0]          sio_o,
  input logic                sio_oe_o,
  input logic [REG_BITS-1:0] prot_o
);
  // R5
  oe_off_after_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |=> !sio_oe_o);

  // R5
  oe_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sio_oe_o |-> $past(!cs_ni));

  // R11
  prot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |=> $stable(prot_o));

  // R11
  prot_change_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prot_o) |-> $past(cs_ni));

  // R11
  sio_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sck_i) |=> $stable(sio_o));
endmodule

bind quad_prot_slave quad_prot_slave_chk #(.REG_BITS(REG_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sck_i    (sck_i),
  .cs_ni    (cs_ni),
  .sio_o    (sio_o),
  .sio_oe_o (sio_oe_o),
  .prot_o   (prot_o)
);

// File: tb/quad_prot_slave_test.sv
module quad_prot_slave_test;
  typedef struct packed {
    logic [7:0]  op;
    logic [5:0]  nibs;
    logic        mode3;
    logic [79:0] data;
  } vec_t;

  localparam logic [79:0] DAT_A = 80'hA5C3_9E17_4B2D_6666_6666;
  localparam logic [79:0] DAT_B = 80'h1357_9BDF_0246_8ACE_F00D;
  localparam logic [79:0] DAT_C = 80'h0F1E_2D3C_4B5A_6978_8796;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'h72, 6'd26, 1'b0, 80'h0},   // reset value, zero fill
    '{8'h42, 6'd12, 1'b0, DAT_A},   // exact for 48, short for 80
    '{8'h72, 6'd24, 1'b1, 80'h0},   // mode 3 read
    '{8'h42, 6'd20, 1'b1, DAT_B},   // exact for 80, long for 48
    '{8'h72, 6'd3,  1'b0, 80'h0},   // aborted read
    '{8'h72, 6'd44, 1'b0, 80'h0},   // full read, zero fill past 80
    '{8'h42, 6'd11, 1'b0, DAT_C},   // one nibble short
    '{8'h42, 6'd13, 1'b1, DAT_C},   // one nibble long for 48
    '{8'h24, 6'd12, 1'b0, DAT_C},   // swapped write opcode
    '{8'h05, 6'd20, 1'b1, DAT_C},   // unknown opcode
    '{8'h72, 6'd22, 1'b1, 80'h0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck_i = 1'b0;
  logic        cs_ni = 1'b1;
  logic [3:0]  sio_i = 4'h0;
  logic [3:0]  sio_a, sio_b;
  logic        oe_a, oe_b;
  logic [47:0] prot_a;
  logic [79:0] prot_b;
  logic [47:0] exp_a = '1;
  logic [79:0] exp_b = '1;
  int          checks = 0;
  int          fails = 0;

  always #4 clk_i = ~clk_i;

  quad_prot_slave #(.REG_BITS(48)) uut (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .sio_i,
    .sio_o(sio_a), .sio_oe_o(oe_a), .prot_o(prot_a)
  );

  quad_prot_slave #(.REG_BITS(80)) uut_w (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .sio_i,
    .sio_o(sio_b), .sio_oe_o(oe_b), .prot_o(prot_b)
  );

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // One nibble: drop SCK, drive data, observe, raise SCK.
  task automatic nib(input logic [3:0] v, output logic [3:0] oa, output logic [3:0] ob,
                     output logic ea, output logic eb);
    sck_i = 1'b0;
    step(2);
    sio_i = v;
    step(2);
    oa = sio_a; ob = sio_b; ea = oe_a; eb = oe_b;
    sck_i = 1'b1;
    step(2);
  endtask

  task automatic run(input vec_t v);
    logic [3:0] oa, ob, d, ea_n, eb_n;
    logic       ea, eb;
    sck_i = v.mode3;
    step(2);
    cs_ni = 1'b0;
    step(2);
    nib(v.op[7:4], oa, ob, ea, eb);
    chk("R5 oe in opcode (48)", 80'(ea), 80'(0));
    chk("R5 oe in opcode (80)", 80'(eb), 80'(0));
    nib(v.op[3:0], oa, ob, ea, eb);
    for (int k = 0; k < int'(v.nibs); k++) begin
      d = (k < 20) ? v.data[79-4*k -: 4] : 4'h0;
      nib(d, oa, ob, ea, eb);
      if (v.op == 8'h72) begin
        ea_n = (k < 12) ? exp_a[47-4*k -: 4] : 4'h0;
        eb_n = (k < 20) ? exp_b[79-4*k -: 4] : 4'h0;
        chk((k < 12) ? "R3 read nibble (48) R9" : "R4 zero fill (48)", 80'(oa), 80'(ea_n));
        chk((k < 20) ? "R3 read nibble (80) R10" : "R4 zero fill (80)", 80'(ob), 80'(eb_n));
        chk("R5 oe in read (48)", 80'(ea), 80'(1));
        chk("R5 oe in read (80)", 80'(eb), 80'(1));
      end else begin
        chk("R5 R8 oe off (48)", 80'(ea), 80'(0));
        chk("R5 R8 oe off (80)", 80'(eb), 80'(0));
      end
    end
    if (!v.mode3) sck_i = 1'b0;
    step(2);
    cs_ni = 1'b1;
    step(3);
    if (v.op == 8'h42 && v.nibs == 6'd12) exp_a = v.data[79:32];
    if (v.op == 8'h42 && v.nibs == 6'd20) exp_b = v.data;
    chk("R6 R7 R8 R10 prot (48)", 80'(prot_a), 80'(exp_a));
    chk("R6 R7 R8 R10 prot (80)", 80'(prot_b), exp_b);
    chk("R5 oe after cs (48)", 80'(oe_a), 80'(0));
    chk("R5 oe after cs (80)", 80'(oe_b), 80'(0));
  endtask

  initial begin
    logic [3:0] oa, ob;
    logic       ea, eb;
    step(3);
    chk("R1 reset prot (48)", 80'(prot_a), 80'({48{1'b1}}));
    chk("R1 reset prot (80)", 80'(prot_b), {80{1'b1}});
    chk("R1 reset oe", 80'({oe_a, oe_b}), 80'(0));
    rst_ni = 1'b1;
    step(2);

    for (int i = 0; i < NV; i++) run(VEC[i]);

    // R2 R6 R10: write both sizes in turn, then read back
    run('{8'h42, 6'd20, 1'b0, DAT_C});
    run('{8'h42, 6'd12, 1'b1, DAT_B});
    run('{8'h72, 6'd24, 1'b0, 80'h0});

    // R1: reset in the middle of a write
    cs_ni = 1'b0;
    step(2);
    for (int i = 0; i < 7; i++) nib((i == 0) ? 4'h4 : (i == 1) ? 4'h2 : 4'h9, oa, ob, ea, eb);
    rst_ni = 1'b0;
    step(1);
    exp_a = '1;
    exp_b = '1;
    chk("R1 mid-write reset (48)", 80'(prot_a), 80'(exp_a));
    chk("R1 mid-write reset (80)", 80'(prot_b), exp_b);
    cs_ni = 1'b1;
    sck_i = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(2);
    run('{8'h72, 6'd22, 1'b1, 80'h0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired, R1 to R11 incomplete act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule